// File: doc/BRIEF.md
# Store Write Buffer with Read-Miss Bypass

This block is a small in-order queue of pending stores. It sits between a write-through cache and a slower main memory. Each processor store goes into the cache and, in the same operation, into this queue through the store port. The memory port then drains the queued writes one at a time, oldest first, while the processor keeps running.

When the cache misses on a read, the missed address is looked up among the pending entries. Only valid entries take part, and the comparison is on word addresses. If no entry holds that word, the read goes to memory ahead of the queued writes; a write that is already in flight finishes first. If one or more entries hold the word, the data of the most recently queued of them is handed back in the same cycle and memory is not read. A full queue holds off further stores until an entry drains.

Top module: `wbuf_bypass`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1, `mem_req` is 0 and `rd_gnt` is 0.
- R2: A store is taken on a cycle with `st_valid` and `st_ready` both high. `st_ready` is low exactly when DEPTH (default 4) entries are occupied, and a store offered in that state is not taken.
- R3: In a cycle where a store is taken and a write is retired, the occupancy does not change.
- R4: Queued writes leave in the order they were taken. A write request has `mem_we`=1 and carries the oldest entry's address (all bits) and data on `mem_addr` and `mem_wdata`. When nothing is pending, `mem_req` is 0.
- R5: A pending read miss that matches no entry is put on the memory port (`mem_we`=0, `mem_addr`=`rd_addr`) whenever the port is not already busy with an unfinished request. In that case it goes ahead of any queued write.
- R6: A pending read whose word matches a valid entry is granted in the same cycle with `rd_fwd`=1. `rd_data` is the data of the youngest matching entry, and no memory read is issued.
- R7: Matching uses address bits above bit 1, so the two byte-offset bits are ignored. An entry that has drained no longer matches.
- R8: Once `mem_req` is raised, `mem_we`, `mem_addr` and `mem_wdata` hold until the cycle that `mem_ack` is high.
- R9: A read served by memory is granted in the cycle `mem_ack` is high, with `rd_fwd`=0 and `rd_data` equal to `mem_rdata`.
- R10: A read already issued to memory is completed from memory, even if a store to the same word is queued while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Queue can take a store |
| st_addr | input | AW | Store byte address |
| st_data | input | DW | Store data |
| rd_req | input | 1 | Read miss pending; held until granted |
| rd_addr | input | AW | Read miss byte address |
| rd_gnt | output | 1 | Read completes this cycle |
| rd_fwd | output | 1 | Read data came from the queue |
| rd_data | output | DW | Read result |
| mem_req | output | 1 | Memory request; held until acknowledged |
| mem_we | output | 1 | 1 = write from queue, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, valid with `mem_ack` on a read |

## Verification
A wrong head pointer or a lost entry shows up on the next retired write: it carries the wrong address or data, or it is missing. A stale valid bit or a wrong age order shows up at the next matching read miss as a wrong forwarded value, or as a forward where a memory read was due. An occupancy count that drifts shows up as `st_ready` disagreeing with the number of stores taken minus writes retired, in the cycle the count crosses DEPTH. A memory-port owner state that is lost shows up at once as a request whose address or direction changes before it is acknowledged.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RD   = 2'd1,
    OWN_WR   = 2'd2
  } mem_owner_e;

  // Physical slot that holds the entry of age k (0 = oldest) given the head.
  function automatic int unsigned slot_of(int unsigned head, int unsigned k,
                                          int unsigned depth);
    return (head + k) % depth;
  endfunction

  // Circular pointer step for any depth, power of two or not.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [AW-1:0]    push_addr,
  input  logic [DW-1:0]    push_data,
  input  logic             pop,
  output logic [AW-1:0]    ent_addr [DEPTH],
  output logic [DW-1:0]    ent_data [DEPTH],
  output logic [DEPTH-1:0] ent_valid,
  output logic [PW-1:0]    head_ptr,
  output logic [AW-1:0]    head_addr,
  output logic [DW-1:0]    head_data,
  output logic [CW-1:0]    occ,
  output logic             full,
  output logic             empty
);
  import wbuf_pkg::*;

  localparam logic [CW-1:0] OCC_MAX = CW'(DEPTH);

  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= PW'(ptr_step(int'(wr_ptr), DEPTH));
      if (pop)  rd_ptr <= PW'(ptr_step(int'(rd_ptr), DEPTH));
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_valid[g] <= 1'b0;
        ent_addr[g]  <= '0;
        ent_data[g]  <= '0;
      end else if (push && (wr_ptr == PW'(g))) begin
        ent_valid[g] <= 1'b1;
        ent_addr[g]  <= push_addr;
        ent_data[g]  <= push_data;
      end else if (pop && (rd_ptr == PW'(g))) begin
        ent_valid[g] <= 1'b0;
      end
    end
  end

  assign head_ptr  = rd_ptr;
  assign head_addr = ent_addr[rd_ptr];
  assign head_data = ent_data[rd_ptr];
  assign full      = (occ == OCC_MAX);
  assign empty     = (occ == '0);

endmodule

// File: rtl/wbuf_match.sv
module wbuf_match #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int OFS_W = 2
) (
  input  logic [AW-1:0]    look_addr,
  input  logic [AW-1:0]    ent_addr [DEPTH],
  input  logic [DW-1:0]    ent_data [DEPTH],
  input  logic [DEPTH-1:0] ent_valid,
  input  logic [PW-1:0]    head_ptr,
  output logic             hit,
  output logic [DW-1:0]    hit_data
);
  import wbuf_pkg::*;

  // Word-level equality: the byte-offset bits are shifted out.
  function automatic logic same_word(logic [AW-1:0] a, logic [AW-1:0] b);
    return ((a ^ b) >> OFS_W) == '0;
  endfunction

  logic [DEPTH-1:0] slot_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign slot_hit[g] = ent_valid[g] && same_word(ent_addr[g], look_addr);
  end

  // Walk from oldest to youngest; the last hit seen is the youngest.
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int unsigned s;
      s = slot_of(int'(head_ptr), k, DEPTH);
      if (slot_hit[s]) begin
        hit      = 1'b1;
        hit_data = ent_data[s];
      end
    end
  end

endmodule

// File: rtl/wbuf_arb.sv
module wbuf_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_want,
  input  logic wr_want,
  input  logic mem_ack,
  output logic sel_rd,
  output logic sel_wr,
  output logic rd_owned,
  output logic port_idle
);
  import wbuf_pkg::*;

  mem_owner_e owner;
  mem_owner_e owner_nxt;

  always_comb begin
    sel_rd = 1'b0;
    sel_wr = 1'b0;
    unique case (owner)
      OWN_RD:  sel_rd = 1'b1;
      OWN_WR:  sel_wr = 1'b1;
      default: begin
        if (rd_want)      sel_rd = 1'b1;
        else if (wr_want) sel_wr = 1'b1;
      end
    endcase
  end

  always_comb begin
    owner_nxt = OWN_NONE;
    if ((sel_rd || sel_wr) && !mem_ack)
      owner_nxt = sel_rd ? OWN_RD : OWN_WR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= OWN_NONE;
    else        owner <= owner_nxt;
  end

  assign rd_owned  = (owner == OWN_RD);
  assign port_idle = (owner == OWN_NONE);

endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          rd_req,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_gnt,
  output logic          rd_fwd,
  output logic [DW-1:0] rd_data,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [DEPTH-1:0] ent_valid;
  logic [PW-1:0]    head_ptr;
  logic [AW-1:0]    head_addr;
  logic [DW-1:0]    head_data;
  logic [CW-1:0]    occ;
  logic             full;
  logic             empty;
  logic             match_hit;
  logic [DW-1:0]    match_data;
  logic             sel_rd;
  logic             sel_wr;
  logic             rd_owned;
  logic             port_idle;

  // Named internal events, visible to the bound checker.
  logic ev_push;
  logic ev_pop;
  logic ev_fwd;
  logic ev_rd_miss;

  assign st_ready   = !full;
  assign ev_push    = st_valid && st_ready;
  assign ev_fwd     = rd_req && match_hit && !rd_owned;
  assign ev_rd_miss = rd_req && !ev_fwd;
  assign ev_pop     = sel_wr && mem_ack;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .PW(PW), .CW(CW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .push_addr (st_addr),
    .push_data (st_data),
    .pop       (ev_pop),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_valid (ent_valid),
    .head_ptr  (head_ptr),
    .head_addr (head_addr),
    .head_data (head_data),
    .occ       (occ),
    .full      (full),
    .empty     (empty)
  );

  wbuf_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .PW(PW)) u_match (
    .look_addr (rd_addr),
    .ent_addr  (ent_addr),
    .ent_data  (ent_data),
    .ent_valid (ent_valid),
    .head_ptr  (head_ptr),
    .hit       (match_hit),
    .hit_data  (match_data)
  );

  wbuf_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_want   (ev_rd_miss),
    .wr_want   (!empty),
    .mem_ack   (mem_ack),
    .sel_rd    (sel_rd),
    .sel_wr    (sel_wr),
    .rd_owned  (rd_owned),
    .port_idle (port_idle)
  );

  assign mem_req   = sel_rd || sel_wr;
  assign mem_we    = sel_wr;
  assign mem_addr  = sel_rd ? rd_addr : head_addr;
  assign mem_wdata = sel_wr ? head_data : '0;

  assign rd_gnt  = ev_fwd || (sel_rd && mem_ack);
  assign rd_fwd  = ev_fwd;
  assign rd_data = ev_fwd ? match_data : mem_rdata;

endmodule

// File: rtl/wbuf_bypass_chk.sv
module wbuf_bypass_chk #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 4,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             st_ready,
  input logic             rd_req,
  input logic             rd_gnt,
  input logic             rd_fwd,
  input logic             mem_req,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [DW-1:0]    mem_wdata,
  input logic             mem_ack,
  input logic             ev_push,
  input logic             ev_pop,
  input logic             ev_fwd,
  input logic [CW-1:0]    occ,
  input logic [DEPTH-1:0] ent_valid,
  input logic             match_hit,
  input logic             rd_owned,
  input logic             port_idle
);
  localparam logic [CW-1:0] OCC_MAX = CW'(DEPTH);

  a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (occ == '0) && !mem_req && !rd_gnt);

  a_r2_full_blocks_store: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == OCC_MAX) |-> !st_ready);

  a_r2_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_MAX);

  a_r3_push_pop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_push && ev_pop) |=> (occ == $past(occ)));

  a_r7_valid_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ent_valid) == int'(occ));

  a_r5_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (port_idle && rd_req && !match_hit) |-> (mem_req && !mem_we));

  a_r6_fwd_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fwd |-> (rd_gnt && rd_fwd && !(mem_req && !mem_we)));

  a_r8_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)
                               && (!mem_we || $stable(mem_wdata))));

  a_r9_mem_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_gnt && !rd_fwd) |-> (mem_req && !mem_we && mem_ack));

  a_r10_owned_from_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_owned && rd_req) |-> !rd_fwd);

  a_r4_pop_is_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop |-> (mem_req && mem_we && mem_ack));

endmodule

bind wbuf_bypass wbuf_bypass_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .st_ready  (st_ready),
  .rd_req    (rd_req),
  .rd_gnt    (rd_gnt),
  .rd_fwd    (rd_fwd),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .ev_push   (ev_push),
  .ev_pop    (ev_pop),
  .ev_fwd    (ev_fwd),
  .occ       (occ),
  .ent_valid (ent_valid),
  .match_hit (match_hit),
  .rd_owned  (rd_owned),
  .port_idle (port_idle)
);

// File: tb/tb_wbuf_bypass.sv
`timescale 1ns/100ps
module tb_wbuf_bypass;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_valid = 1'b0;
  logic        st_ready;
  logic [31:0] st_addr = '0;
  logic [31:0] st_data = '0;
  logic        rd_req = 1'b0;
  logic [31:0] rd_addr = '0;
  logic        rd_gnt;
  logic        rd_fwd;
  logic [31:0] rd_data;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  wbuf_bypass #(.AW(32), .DW(32), .DEPTH(DEPTH)) dut (.*);

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] qa[$];
  logic [31:0] qd[$];
  logic [31:0] mem_m [logic [29:0]];
  int  owner = 0;       // 0 idle, 1 read in flight, 2 write in flight
  bit  stall = 0;
  bit  last_acc = 0;
  bit  last_gnt = 0;
  bit  done = 0;

  function automatic logic [31:0] memval(logic [29:0] w);
    if (mem_m.exists(w)) return mem_m[w];
    return 32'h5A00_0000 ^ ({2'b0, w} * 32'h0000_9E37);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge with inputs set; returns at the next one.
  task automatic run_cycle();
    bit hit, fwd_e, rd_e, wr_e;
    logic [31:0] hd;
    #1;
    mem_ack = 1'b0;
    mem_rdata = '0;
    if (mem_req && !stall && ($urandom % 3 != 0)) begin
      mem_ack = 1'b1;
      if (!mem_we) mem_rdata = memval(mem_addr[31:2]);
    end
    #0.5;
    chk(st_ready == (qa.size() < DEPTH), "R2 st_ready", 32'(st_ready), 32'(qa.size() < DEPTH));
    hit = 0; hd = '0;
    foreach (qa[i]) if (qa[i][31:2] == rd_addr[31:2]) begin hit = 1; hd = qd[i]; end
    fwd_e = rd_req && hit && (owner != 1);
    rd_e  = rd_req && !fwd_e && (owner != 2);
    wr_e  = (owner == 2) || (owner == 0 && !(rd_req && !fwd_e) && qa.size() > 0);
    if (fwd_e) begin
      chk(rd_gnt && rd_fwd, "R6 forward grant", {30'b0, rd_gnt, rd_fwd}, 32'h3);
      chk(rd_data == hd, "R6 R7 youngest data", rd_data, hd);
      chk(!(mem_req && !mem_we), "R6 no memory read", 32'(mem_req && !mem_we), 32'h0);
    end else if (rd_req) begin
      chk(!rd_fwd, (owner == 1) ? "R10 no forward" : "R5 no forward", 32'(rd_fwd), 32'h0);
      if (rd_e) begin
        chk(mem_req && !mem_we && mem_addr[31:2] == rd_addr[31:2],
            (owner == 1) ? "R10 read held" : "R5 read issued", mem_addr, rd_addr);
        chk(rd_gnt == mem_ack, "R9 grant on ack", 32'(rd_gnt), 32'(mem_ack));
        if (rd_gnt) chk(rd_data == memval(rd_addr[31:2]), "R9 memory data", rd_data,
                        memval(rd_addr[31:2]));
      end else begin
        chk(!rd_gnt, "R8 read waits", 32'(rd_gnt), 32'h0);
      end
    end else begin
      chk(!rd_gnt, "R9 no stray grant", 32'(rd_gnt), 32'h0);
    end
    if (wr_e) begin
      chk(mem_req && mem_we, "R4 write selected", {30'b0, mem_req, mem_we}, 32'h3);
      chk(mem_addr == qa[0], "R4 R8 write address", mem_addr, qa[0]);
      chk(mem_wdata == qd[0], "R4 R8 write data", mem_wdata, qd[0]);
    end else if (!rd_e) begin
      chk(!mem_req, "R4 port quiet", 32'(mem_req), 32'h0);
    end
    // model update for the coming rising edge
    last_acc = st_valid && st_ready;
    last_gnt = rd_gnt;
    if (mem_req && mem_ack && mem_we && qa.size() > 0) begin
      mem_m[qa[0][31:2]] = qd[0];
      void'(qa.pop_front());
      void'(qd.pop_front());
    end
    if (last_acc) begin qa.push_back(st_addr); qd.push_back(st_data); end
    owner = (mem_req && !mem_ack) ? (mem_we ? 2 : 1) : 0;
    @(negedge clk);
  endtask

  function automatic logic [31:0] rnd_addr();
    return 32'h100 + 32'(($urandom % 8) * 4) + 32'($urandom % 4);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1.5;
    // R1: idle after reset
    chk(st_ready && !mem_req && !rd_gnt, "R1 reset state",
        {29'b0, st_ready, mem_req, rd_gnt}, 32'h4);
    @(negedge clk);

    // R2: fill with memory stalled; fifth store is held off
    stall = 1;
    for (int i = 0; i < 5; i++) begin
      st_valid = 1; st_addr = 32'h400 + 32'(i * 4); st_data = 32'hA000 + 32'(i);
      run_cycle();
    end
    chk(st_ready == 1'b0 && qa.size() == DEPTH, "R2 full stall", 32'(qa.size()), 32'(DEPTH));
    run_cycle();
    st_valid = 0;
    stall = 0;
    for (int i = 0; i < 40 && (qa.size() > 0 || owner != 0); i++) run_cycle();
    chk(qa.size() == 0, "R4 drained", 32'(qa.size()), 32'h0);
    st_valid = 1; st_addr = 32'h410; st_data = 32'hA004;   // the held-off store
    run_cycle();
    st_valid = 0;
    for (int i = 0; i < 40 && (qa.size() > 0 || owner != 0); i++) run_cycle();

    // R6/R7: two stores to one word, read at another byte offset forwards youngest
    stall = 1;
    st_valid = 1; st_addr = 32'h100; st_data = 32'h11; run_cycle();
    st_addr = 32'h101; st_data = 32'h22; run_cycle();
    st_valid = 0;
    rd_req = 1; rd_addr = 32'h103; run_cycle();
    chk(last_gnt, "R6 R7 forward seen", 32'(last_gnt), 32'h1);
    rd_req = 0;
    stall = 0;
    for (int i = 0; i < 40 && (qa.size() > 0 || owner != 0); i++) run_cycle();

    // R5: miss read wins over a queued write when the port is idle
    stall = 1;
    st_valid = 1; st_addr = 32'h140; st_data = 32'h33; run_cycle();
    st_valid = 0;
    rd_req = 1; rd_addr = 32'h300; run_cycle();
    // R10: matching store arrives while the read is in flight
    st_valid = 1; st_addr = 32'h302; st_data = 32'h44; run_cycle();
    st_valid = 0;
    stall = 0;
    for (int i = 0; i < 40 && !last_gnt; i++) run_cycle();
    rd_req = 0;
    for (int i = 0; i < 40 && (qa.size() > 0 || owner != 0); i++) run_cycle();

    // R7: drained word no longer matches; memory holds youngest data (R4)
    rd_req = 1; rd_addr = 32'h102;
    for (int i = 0; i < 40 && !last_gnt; i++) run_cycle();
    chk(memval(30'h40) == 32'h22, "R4 R7 youngest retired last", memval(30'h40), 32'h22);
    rd_req = 0;
    run_cycle();

    // random phase
    for (int c = 0; c < 6000; c++) begin
      if (st_valid && last_acc) st_valid = 0;
      if (!st_valid && ($urandom % 2 == 0)) begin
        st_valid = 1; st_addr = rnd_addr(); st_data = $urandom;
      end
      if (rd_req && last_gnt) rd_req = 0;
      else if (!rd_req && ($urandom % 4 == 0)) begin
        rd_req = 1; rd_addr = rnd_addr();
      end
      stall = ($urandom % 8 == 0);
      run_cycle();
    end
    st_valid = 0; stall = 0;
    if (rd_req && last_gnt) rd_req = 0;
    for (int i = 0; i < 100 && (rd_req || qa.size() > 0 || owner != 0); i++) begin
      run_cycle();
      if (rd_req && last_gnt) rd_req = 0;
    end
    chk(qa.size() == 0 && !mem_req, "R4 final drain", 32'(qa.size()), 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule